// File: doc/BRIEF.md
# Key-Locked System Control Register Bank

This block is a word-addressed bank of system control registers on a simple 32-bit bus. The bus has a select, a write strobe, a byte offset and write data. Read data comes from a register and is valid in the cycle after the access.

The bank holds the following:
- A strapped identification word, whose variant field picks how reset control behaves.
- An LED register that also drives output pins.
- Two general configuration words.
- A lock register that opens only when written with a magic key.
- A volatile flag register and a non-volatile flag register. Each has a set address and a clear address.
- A reset control register. On boards that have it, this register can raise a one-cycle system reset request, but only while the lock is open.
- Constant and strapped read-only words, and a set of placeholder offsets that read as zero.

A request to reset control is handled by a two-state sequencer:
- `RQ_IDLE` moves to `RQ_FIRE` on an accepted reset-control write whose trigger bit is set (transition "fire").
- `RQ_FIRE` drives the request output. It returns to `RQ_IDLE` on the next cycle ("expire"), or stays in `RQ_FIRE` if another triggering write lands in that cycle ("refire").
- Every other case holds `RQ_IDLE` ("hold").

Accesses to offsets outside the map read as zero, change nothing, and raise a one-cycle bad-address flag.

Top module: `sysctl_bank`

## Requirements
- R1: A read of offset 0x00 returns `id_strap`. All read data appears on `bus_rdata` in the cycle after the read access, and write accesses leave `bus_rdata` at zero. The variant code is `id_strap[27:16]`.
- R2: A write to the lock at 0x20 stores 0xA05F only when the full 32-bit data equals 0x0000A05F. Any other data stores `data[15:0] & 0x7FFF`. A read of 0x20 returns the stored 16-bit value, zero-extended.
- R3: A write to 0x30 ORs the data into the flag register, and a write to 0x34 clears the flag bits set in the data. A read of 0x30 returns the flags, and a read of 0x34 returns zero.
- R4: The non-volatile flags behave the same way at 0x38 (set, and read) and 0x3C (clear, reads zero). They are cleared only by `por_n` and keep their value through `rst_n`.
- R5: A write to reset control at 0x40 is stored only while the lock holds 0xA05F. On a supported variant, a read of 0x40 returns the stored level.
- R6: On variant 0x100, bit 8 of an accepted reset-control write raises `rst_req`. On variants 0x178 and 0x182, bit 2 raises it. `rst_req` is high for exactly the cycle after the write.
- R7: On any other variant, reset control reads zero, stores nothing, and never raises `rst_req`.
- R8: `rst_n` low clears the LED, lock, both configuration words, the flags and the reset level. The LED register drives `led_out`.
- R9: Offset 0x44 reads 1, 0x88 reads 0xFF000000 and 0x84 reads `proc_strap`. Offsets 0x04, 0x0C–0x1C, 0x24, 0x48–0x80 and 0x8C–0x9C read zero and ignore writes.
- R10: Every other offset reads zero and ignores writes. `bad_addr` is high for exactly the cycle after any access to such an offset.
- R11: Writes to 0x08, 0x28 and 0x2C store the full word, which reads back at the same offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Block reset, asynchronous, active low |
| por_n | input | 1 | Power-on reset for the non-volatile flags, active low |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| id_strap | input | 32 | Strapped identification word |
| proc_strap | input | 32 | Strapped processor identifier |
| bus_rdata | output | 32 | Registered read data |
| bad_addr | output | 1 | One-cycle pulse after an unmapped access |
| rst_req | output | 1 | One-cycle system reset request |
| led_out | output | 32 | LED register contents |

## Verification
The bench builds the bank with its default parameters:
- a 12-bit offset, so offsets up to 0xFFC and well past the map are reachable;
- the 0xA05F key;
- trigger bits 8 and 2 for the three variant codes.

Because the identification strap is an input, the bench can switch between the old variant, both newer variants and an unsupported one within one run. Each reset-control path and the zero-read path are therefore exercised with the same lock and flag history.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    typedef enum logic [3:0] {
        RK_BAD,
        RK_ZERO,
        RK_ID,
        RK_LED,
        RK_LOCK,
        RK_CFG1,
        RK_CFG2,
        RK_FSET,
        RK_FCLR,
        RK_NSET,
        RK_NCLR,
        RK_RCTL,
        RK_ONE,
        RK_PROC,
        RK_PROCHI
    } reg_kind_e;

    typedef enum logic {
        RQ_IDLE,
        RQ_FIRE
    } rq_state_e;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_kind_e         kind_o
);
    localparam int IDX_W = ADDR_W - 2;

    localparam logic [IDX_W-1:0] W_ID     = IDX_W'(0);
    localparam logic [IDX_W-1:0] W_LED    = IDX_W'(2);
    localparam logic [IDX_W-1:0] W_LOCK   = IDX_W'(8);
    localparam logic [IDX_W-1:0] W_CFG1   = IDX_W'(10);
    localparam logic [IDX_W-1:0] W_CFG2   = IDX_W'(11);
    localparam logic [IDX_W-1:0] W_FSET   = IDX_W'(12);
    localparam logic [IDX_W-1:0] W_FCLR   = IDX_W'(13);
    localparam logic [IDX_W-1:0] W_NSET   = IDX_W'(14);
    localparam logic [IDX_W-1:0] W_NCLR   = IDX_W'(15);
    localparam logic [IDX_W-1:0] W_RCTL   = IDX_W'(16);
    localparam logic [IDX_W-1:0] W_ONE    = IDX_W'(17);
    localparam logic [IDX_W-1:0] W_PROC   = IDX_W'(33);
    localparam logic [IDX_W-1:0] W_PROCHI = IDX_W'(34);

    logic [IDX_W-1:0] idx;
    logic             zero_hit;

    assign idx = addr_i[ADDR_W-1:2];

    always_comb begin
        zero_hit = (idx == IDX_W'(1)) || (idx == IDX_W'(9)) ||
                   ((idx >= IDX_W'(3))  && (idx <= IDX_W'(7)))  ||
                   ((idx >= IDX_W'(18)) && (idx <= IDX_W'(32))) ||
                   ((idx >= IDX_W'(35)) && (idx <= IDX_W'(39)));
    end

    always_comb begin
        unique case (idx)
            W_ID:     kind_o = RK_ID;
            W_LED:    kind_o = RK_LED;
            W_LOCK:   kind_o = RK_LOCK;
            W_CFG1:   kind_o = RK_CFG1;
            W_CFG2:   kind_o = RK_CFG2;
            W_FSET:   kind_o = RK_FSET;
            W_FCLR:   kind_o = RK_FCLR;
            W_NSET:   kind_o = RK_NSET;
            W_NCLR:   kind_o = RK_NCLR;
            W_RCTL:   kind_o = RK_RCTL;
            W_ONE:    kind_o = RK_ONE;
            W_PROC:   kind_o = RK_PROC;
            W_PROCHI: kind_o = RK_PROCHI;
            default:  kind_o = zero_hit ? RK_ZERO : RK_BAD;
        endcase
    end

endmodule

// File: rtl/sysctl_rstseq.sv
module sysctl_rstseq
    import sysctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic req_o
);
    rq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            RQ_IDLE: state_d = fire_i ? RQ_FIRE : RQ_IDLE;
            RQ_FIRE: state_d = fire_i ? RQ_FIRE : RQ_IDLE;
            default: state_d = RQ_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            RQ_FIRE: req_o = 1'b1;
            default: req_o = 1'b0;
        endcase
    end

    // R6: a trigger is followed by the request in the next cycle
    assert_fire_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> req_o);
    // R6: no request without a trigger one cycle earlier
    assert_req_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> $past(fire_i));

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int              DATA_W   = 32,
    parameter int              LOCK_W   = 16,
    parameter logic [15:0]     LOCK_KEY = 16'hA05F,
    parameter int              BIT_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              acc_i,
    input  logic              wr_i,
    input  reg_kind_e         kind_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] id_i,
    input  logic [DATA_W-1:0] proc_i,
    input  logic              trig_ok_i,
    input  logic [BIT_W-1:0]  trig_bit_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] led_o,
    output logic              fire_o
);
    localparam logic [LOCK_W-1:0] KEY_L     = LOCK_W'(LOCK_KEY);
    localparam logic [DATA_W-1:0] KEY_WORD  = DATA_W'(KEY_L);
    localparam logic [LOCK_W-1:0] KEEP_MASK = {1'b0, {(LOCK_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] ONE_WORD  = DATA_W'(1);
    localparam logic [DATA_W-1:0] HI_WORD   = {8'hFF, {(DATA_W-8){1'b0}}};

    logic [DATA_W-1:0] led_q, cfg1_q, cfg2_q, flags_q, nv_q, rlev_q;
    logic [LOCK_W-1:0] lock_q;
    logic [DATA_W-1:0] rd_next;
    logic              wr_en, rd_en, lock_open;

    assign wr_en     = acc_i && wr_i;
    assign rd_en     = acc_i && !wr_i;
    assign lock_open = (lock_q == KEY_L);
    assign led_o     = led_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            led_q   <= '0;
            lock_q  <= '0;
            cfg1_q  <= '0;
            cfg2_q  <= '0;
            flags_q <= '0;
            rlev_q  <= '0;
        end else if (wr_en) begin
            unique case (kind_i)
                RK_LED:  led_q   <= wdata_i;
                RK_LOCK: lock_q  <= (wdata_i == KEY_WORD) ? KEY_L
                                    : (wdata_i[LOCK_W-1:0] & KEEP_MASK);
                RK_CFG1: cfg1_q  <= wdata_i;
                RK_CFG2: cfg2_q  <= wdata_i;
                RK_FSET: flags_q <= flags_q | wdata_i;
                RK_FCLR: flags_q <= flags_q & ~wdata_i;
                RK_RCTL: if (trig_ok_i && lock_open) rlev_q <= wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            nv_q <= '0;
        end else if (wr_en) begin
            unique case (kind_i)
                RK_NSET: nv_q <= nv_q | wdata_i;
                RK_NCLR: nv_q <= nv_q & ~wdata_i;
                default: ;
            endcase
        end
    end

    assign fire_o = wr_en && (kind_i == RK_RCTL) && trig_ok_i && lock_open
                    && wdata_i[trig_bit_i];

    always_comb begin
        unique case (kind_i)
            RK_ID:     rd_next = id_i;
            RK_LED:    rd_next = led_q;
            RK_LOCK:   rd_next = DATA_W'(lock_q);
            RK_CFG1:   rd_next = cfg1_q;
            RK_CFG2:   rd_next = cfg2_q;
            RK_FSET:   rd_next = flags_q;
            RK_NSET:   rd_next = nv_q;
            RK_RCTL:   rd_next = trig_ok_i ? rlev_q : '0;
            RK_ONE:    rd_next = ONE_WORD;
            RK_PROC:   rd_next = proc_i;
            RK_PROCHI: rd_next = HI_WORD;
            default:   rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata_o <= '0;
        else if (rd_en) rdata_o <= rd_next;
        else            rdata_o <= '0;
    end

    // R2: bit 15 of the lock can only be set by the exact key
    assert_lock_top_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q[LOCK_W-1] |-> (lock_q == KEY_L));
    // R3: set address leaves every written bit set
    assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind_i == RK_FSET) |=> ((flags_q & $past(wdata_i)) == $past(wdata_i)));
    // R3: clear address leaves every written bit clear
    assert_flag_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind_i == RK_FCLR) |=> ((flags_q & $past(wdata_i)) == '0));
    // R4: non-volatile clear address leaves every written bit clear
    assert_nv_clr_R4: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (wr_en && kind_i == RK_NCLR) |=> ((nv_q & $past(wdata_i)) == '0));
    // R5: the reset level cannot move while the lock is closed
    assert_rlev_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_open |=> $stable(rlev_q));
    // R7: reset control reads zero on an unsupported variant
    assert_rctl_raz_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && kind_i == RK_RCTL && !trig_ok_i) |=> (rdata_o == '0));

endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
    import sysctl_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter int          DATA_W    = 32,
    parameter int          LOCK_W    = 16,
    parameter logic [15:0] LOCK_KEY  = 16'hA05F,
    parameter int          VAR_LSB   = 16,
    parameter int          VAR_W     = 12,
    parameter logic [11:0] VAR_OLD   = 12'h100,
    parameter int          OLD_TRIG  = 8,
    parameter logic [11:0] VAR_NEW_A = 12'h178,
    parameter logic [11:0] VAR_NEW_B = 12'h182,
    parameter int          NEW_TRIG  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] id_strap,
    input  logic [DATA_W-1:0] proc_strap,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bad_addr,
    output logic              rst_req,
    output logic [DATA_W-1:0] led_out
);
    localparam int BIT_W = $clog2(DATA_W);

    reg_kind_e        kind;
    logic [VAR_W-1:0] variant;
    logic             trig_ok;
    logic [BIT_W-1:0] trig_bit;
    logic             fire;

    assign variant = id_strap[VAR_LSB +: VAR_W];

    always_comb begin
        if (variant == VAR_W'(VAR_OLD)) begin
            trig_ok  = 1'b1;
            trig_bit = BIT_W'(OLD_TRIG);
        end else if (variant == VAR_W'(VAR_NEW_A) || variant == VAR_W'(VAR_NEW_B)) begin
            trig_ok  = 1'b1;
            trig_bit = BIT_W'(NEW_TRIG);
        end else begin
            trig_ok  = 1'b0;
            trig_bit = '0;
        end
    end

    sysctl_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i (bus_addr),
        .kind_o (kind)
    );

    sysctl_regs #(
        .DATA_W   (DATA_W),
        .LOCK_W   (LOCK_W),
        .LOCK_KEY (LOCK_KEY),
        .BIT_W    (BIT_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .por_n      (por_n),
        .acc_i      (bus_sel),
        .wr_i       (bus_wr),
        .kind_i     (kind),
        .wdata_i    (bus_wdata),
        .id_i       (id_strap),
        .proc_i     (proc_strap),
        .trig_ok_i  (trig_ok),
        .trig_bit_i (trig_bit),
        .rdata_o    (bus_rdata),
        .led_o      (led_out),
        .fire_o     (fire)
    );

    sysctl_rstseq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (fire),
        .req_o  (rst_req)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bad_addr <= 1'b0;
        else        bad_addr <= bus_sel && (kind == RK_BAD);
    end

    // R10: the bad-address flag only follows an access
    assert_bad_after_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bad_addr |-> $past(bus_sel));
    // R10: an unmapped read returns zero
    assert_bad_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bad_addr |-> (bus_rdata == '0));
    // R7: a request needs a supported variant in the write cycle
    assert_req_variant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(trig_ok));

endmodule

// File: tb/sim_sysctl_bank.sv
module sim_sysctl_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0, por_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] id_strap = 32'h0100_0000;
    logic [31:0] proc_strap = 32'h1234_ABCD;
    logic [31:0] bus_rdata, led_out;
    logic        bad_addr, rst_req;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [31:0] m_led, m_cfg1, m_cfg2, m_flags, m_nv, m_rlev;
    logic [15:0] m_lock;
    logic        e_req, e_bad;

    always #2 clk = ~clk;

    sysctl_bank u0 (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .id_strap(id_strap),
        .proc_strap(proc_strap), .bus_rdata(bus_rdata), .bad_addr(bad_addr),
        .rst_req(rst_req), .led_out(led_out)
    );

    // class codes: 0 bad, 1 zero, 2 id, 3 led, 4 lock, 5 cfg1, 6 cfg2, 7 fset,
    // 8 fclr, 9 nset, 10 nclr, 11 rctl, 12 one, 13 proc, 14 prochi
    function automatic int cls(logic [11:0] a);
        int w = int'(a >> 2);
        case (w)
            0: return 2;   2: return 3;   8: return 4;  10: return 5;
            11: return 6; 12: return 7;  13: return 8;  14: return 9;
            15: return 10; 16: return 11; 17: return 12; 33: return 13;
            34: return 14;
            default: begin
                if (w == 1 || w == 9 || (w >= 3 && w <= 7) || (w >= 18 && w <= 32)
                    || (w >= 35 && w <= 39)) return 1;
                return 0;
            end
        endcase
    endfunction

    function automatic logic var_ok(logic [31:0] id);
        return id[27:16] == 12'h100 || id[27:16] == 12'h178 || id[27:16] == 12'h182;
    endfunction

    function automatic int var_bit(logic [31:0] id);
        return (id[27:16] == 12'h100) ? 8 : 2;
    endfunction

    function automatic logic [31:0] exp_rd(logic [11:0] a);
        case (cls(a))
            2: return id_strap;
            3: return m_led;
            4: return {16'h0, m_lock};
            5: return m_cfg1;
            6: return m_cfg2;
            7: return m_flags;
            9: return m_nv;
            11: return var_ok(id_strap) ? m_rlev : 32'h0;
            12: return 32'h1;
            13: return proc_strap;
            14: return 32'hFF00_0000;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(logic wr, logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic model_write(logic [11:0] a, logic [31:0] d);
        logic open = (m_lock == 16'hA05F);
        e_req = 1'b0;
        e_bad = (cls(a) == 0);
        case (cls(a))
            3: m_led = d;
            4: m_lock = (d == 32'h0000_A05F) ? 16'hA05F : (d[15:0] & 16'h7FFF);
            5: m_cfg1 = d;
            6: m_cfg2 = d;
            7: m_flags = m_flags | d;
            8: m_flags = m_flags & ~d;
            9: m_nv = m_nv | d;
            10: m_nv = m_nv & ~d;
            11: if (var_ok(id_strap) && open) begin
                    m_rlev = d;
                    e_req = d[var_bit(id_strap)];
                end
            default: ;
        endcase
    endtask

    task automatic do_write(logic [11:0] a, logic [31:0] d, string req);
        model_write(a, d);
        access(1'b1, a, d);
        check({req, " rst_req"}, {31'h0, rst_req}, {31'h0, e_req});
        check({req, " bad_addr"}, {31'h0, bad_addr}, {31'h0, e_bad});
    endtask

    task automatic do_read(logic [11:0] a, string req);
        logic [31:0] e = exp_rd(a);
        access(1'b0, a, 32'h0);
        check(req, bus_rdata, e);
        check({req, " bad_addr"}, {31'h0, bad_addr}, {31'h0, cls(a) == 0});
    endtask

    task automatic clear_model_volatile();
        m_led = 0; m_lock = 0; m_cfg1 = 0; m_cfg2 = 0; m_flags = 0; m_rlev = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [11:0] offs [20];
        clear_model_volatile();
        m_nv = 0;
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;

        // R8: reset state
        check("R8 led_out after reset", led_out, 32'h0);
        check("R8 rst_req after reset", {31'h0, rst_req}, 32'h0);
        do_read(12'h008, "R8 LED reset");
        do_read(12'h020, "R8 lock reset");
        do_read(12'h030, "R8 flags reset");
        do_read(12'h038, "R4 nv after por");

        // R1, R9 identity and constants
        do_read(12'h000, "R1 id");
        do_read(12'h084, "R9 proc id");
        do_read(12'h088, "R9 0x88 constant");
        do_read(12'h044, "R9 0x44 constant");
        do_write(12'h00C, 32'hFFFF_FFFF, "R9 osc write");
        do_read(12'h00C, "R9 osc reads zero");
        do_write(12'h060, 32'h1234_5678, "R9 placeholder write");
        do_read(12'h060, "R9 placeholder reads zero");

        // R11 plain read/write words
        do_write(12'h008, 32'hA5A5_0F0F, "R11 LED");
        check("R8 led_out drive", led_out, 32'hA5A5_0F0F);
        do_read(12'h008, "R11 LED readback");
        do_write(12'h028, 32'h0BAD_F00D, "R11 cfg1");
        do_write(12'h02C, 32'hCAFE_0001, "R11 cfg2");
        do_read(12'h028, "R11 cfg1 readback");
        do_read(12'h02C, "R11 cfg2 readback");

        // R2 lock
        do_write(12'h020, 32'h0000_FFFF, "R2 lock non-key");
        do_read(12'h020, "R2 lock bit15 cleared");
        do_write(12'h020, 32'h0001_A05F, "R2 key with upper bits");
        do_read(12'h020, "R2 near-key masked");
        do_write(12'h020, 32'h0000_A05F, "R2 exact key");
        do_read(12'h020, "R2 key stored");

        // R3 flags, R4 nv flags
        do_write(12'h030, 32'h0000_00F0, "R3 set");
        do_write(12'h030, 32'h8000_0001, "R3 set more");
        do_write(12'h034, 32'h0000_0030, "R3 clear");
        do_read(12'h030, "R3 flags");
        do_read(12'h034, "R3 clear addr reads zero");
        do_write(12'h038, 32'h00FF_0000, "R4 nv set");
        do_write(12'h03C, 32'h000F_0000, "R4 nv clear");
        do_read(12'h038, "R4 nv value");
        do_read(12'h03C, "R4 nv clear addr reads zero");

        // R5/R6 on variant 0x100
        do_write(12'h020, 32'h0, "R5 close lock");
        do_write(12'h040, 32'h0000_0100, "R5 locked write no request");
        do_read(12'h040, "R5 locked write not stored");
        do_write(12'h020, 32'h0000_A05F, "R5 open lock");
        do_write(12'h040, 32'h0000_0104, "R6 bit8 request");
        @(negedge clk);
        check("R6 request single cycle", {31'h0, rst_req}, 32'h0);
        do_read(12'h040, "R5 level stored");
        do_write(12'h040, 32'h0000_0004, "R6 bit2 ignored on 0x100");

        // R10 unmapped
        do_write(12'h0A0, 32'hFFFF_FFFF, "R10 unmapped write");
        @(negedge clk);
        check("R10 bad single cycle", {31'h0, bad_addr}, 32'h0);
        do_write(12'hFFC, 32'h1, "R10 high offset write");
        do_read(12'h200, "R10 unmapped read");
        do_read(12'h028, "R10 cfg1 untouched");

        // R8/R4 block reset keeps nv flags
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        clear_model_volatile();
        check("R8 led_out cleared", led_out, 32'h0);
        do_read(12'h038, "R4 nv survives block reset");
        do_read(12'h02C, "R8 cfg2 cleared");
        do_read(12'h040, "R8 level cleared");

        // R6 newer variants
        id_strap = 32'h0178_0000;
        do_write(12'h020, 32'h0000_A05F, "R6 open lock");
        do_write(12'h040, 32'h0000_0004, "R6 bit2 on 0x178");
        do_write(12'h040, 32'h0000_0100, "R6 bit8 ignored on 0x178");
        id_strap = 32'h0182_0000;
        do_write(12'h040, 32'h0000_0006, "R6 bit2 on 0x182");
        do_read(12'h040, "R5 level on 0x182");

        // R7 unsupported variant
        id_strap = 32'h0190_0000;
        do_write(12'h040, 32'hFFFF_FFFF, "R7 no request");
        do_read(12'h040, "R7 reads zero");
        id_strap = 32'h0182_0000;
        do_read(12'h040, "R7 write not stored");

        // random mix
        offs = '{12'h000, 12'h004, 12'h008, 12'h020, 12'h020, 12'h028, 12'h02C,
                 12'h030, 12'h034, 12'h038, 12'h03C, 12'h040, 12'h040, 12'h044,
                 12'h084, 12'h088, 12'h070, 12'h0B0, 12'h400, 12'h090};
        void'($urandom(32'd20240611));
        for (int i = 0; i < 400; i++) begin
            logic [11:0] a;
            logic [31:0] d;
            if (i % 50 == 0) begin
                case ($urandom % 4)
                    0: id_strap = 32'h0100_0000 | ($urandom & 32'hF000_FFFF);
                    1: id_strap = 32'h0178_0000 | ($urandom & 32'hF000_FFFF);
                    2: id_strap = 32'h0182_0000 | ($urandom & 32'hF000_FFFF);
                    default: id_strap = 32'h0140_0000;
                endcase
            end
            a = offs[$urandom % 20];
            d = $urandom;
            if (a == 12'h020 && ($urandom % 2 == 0)) d = 32'h0000_A05F;
            if ($urandom % 2 == 0) begin
                do_write(a, d, "R5 R6 random write");
                check("R8 random led_out", led_out, m_led);
            end else begin
                do_read(a, "R1 R9 random read");
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule